// File: doc/BRIEF.md
# Tag-Checked ALU

This block is the logic and pointer-stepping unit of a processor whose every data word carries a small type tag next to its value. Each issued operation names an opcode, two tagged operands and a short immediate. The bitwise operations and both shifts work only on integer-tagged operands. Pointer increment and decrement work only on a pointer-tagged first operand, and their result keeps the pointer tag. No operation takes operands of arbitrary tag and returns a raw, untagged sum or difference.

When an operand carries the wrong tag, or the opcode is not defined, the unit raises a trap with a cause code in place of a result. The pipeline then diverts to its trap path. The result register is forced to zero on a trap, so a faulting operation never lets a half-checked value reach the register file. There is one register stage: a request issued in one cycle gives its answer in the next.

Top module: `tagalu_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `out_trap`, `out_cause`, `out_tag` and `out_val` are all zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. In a cycle that follows one with `in_valid` low, every output is zero.
- R3: Opcodes AND=0, OR=1 and XOR=2 with both tags INT (tag code 0) give the bitwise result of the two values, tagged INT.
- R4: Opcode SHL=3 with both tags INT shifts `a_val` left by the value of `b_val` and fills with zeros. A shift amount of 16 or more gives zero. The result is tagged INT.
- R5: Opcode SHR=4 with both tags INT shifts `a_val` right logically by the value of `b_val` and fills with zeros. A shift amount of 16 or more gives zero. The result is tagged INT.
- R6: Opcode INC=5 with `a_tag` PTR (tag code 1) gives `a_val + in_imm` modulo 2^16, tagged PTR, with no trap on wrap. `b_tag` and `b_val` have no effect.
- R7: Opcode DEC=6 with `a_tag` PTR gives `a_val - in_imm` modulo 2^16, tagged PTR, with no trap on wrap. `b_tag` and `b_val` have no effect.
- R8: Any tag other than the one an opcode requires raises `out_trap` with `out_cause` = 1 (bad tag). This covers CONT=2, CLOSURE=3 and the reserved codes 4 to 7. On a trap, `out_tag` and `out_val` are zero.
- R9: An opcode from 7 to 15 raises `out_trap` with `out_cause` = 2 (bad opcode), whatever the operand tags are. `out_tag` and `out_val` are zero.
- R10: `out_cause` is nonzero exactly when `out_trap` is high, and `out_trap` is high only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_op | input | 4 | Opcode (0 AND, 1 OR, 2 XOR, 3 SHL, 4 SHR, 5 INC, 6 DEC) |
| a_tag | input | 3 | Tag of the first operand |
| a_val | input | 16 | Value of the first operand |
| b_tag | input | 3 | Tag of the second operand |
| b_val | input | 16 | Value of the second operand (shift amount for shifts) |
| in_imm | input | 4 | Unsigned step for INC and DEC |
| out_valid | output | 1 | The result or trap of last cycle's operation is present |
| out_tag | output | 3 | Tag of the result |
| out_val | output | 16 | Value of the result |
| out_trap | output | 1 | The operation faulted |
| out_cause | output | 2 | 0 none, 1 bad tag, 2 bad opcode |

## Verification
The hardest conditions to reach are those where more than one fault or boundary applies at once. Examples are an undefined opcode carrying reserved tags, where the opcode cause must win, and a pointer step that wraps past zero or past the top of the range. Shift amounts that are nonzero only above the low four bits also need care, since a shifter that looks only at the low bits would return a shifted value instead of zero. Directed steps set up each of these collisions on purpose. A long pseudo-random run follows, with tags biased half the time toward the legal tag for the chosen opcode, so that both legal results and traps appear often. A behavioural model in the bench gives the expected outputs for every cycle.

// File: rtl/tagalu_pkg.sv
// Package: tag codes, opcodes and trap causes shared by the tag-checked ALU.
// Assumes a 3-bit tag and a 4-bit opcode field; the data width is a module parameter.
package tagalu_pkg;
    localparam int TAG_W   = 3;
    localparam int OP_W    = 4;
    localparam int CAUSE_W = 2;

    localparam logic [TAG_W-1:0] TAG_INT  = 3'd0;
    localparam logic [TAG_W-1:0] TAG_PTR  = 3'd1;
    localparam logic [TAG_W-1:0] TAG_CONT = 3'd2;
    localparam logic [TAG_W-1:0] TAG_CLOS = 3'd3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_XOR = 4'd2,
        OP_SHL = 4'd3,
        OP_SHR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6
    } op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd6;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TAG  = 2'd1,
        CAUSE_OP   = 2'd2
    } cause_e;
endpackage

// File: rtl/tagalu_decode.sv
// Opcode and tag legality check.
// Assumes opcodes above OP_LAST are undefined; a bad opcode outranks a bad tag.
module tagalu_decode
    import tagalu_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output cause_e           cause,
    output logic             ptr_op
);
    logic op_bad;
    logic tag_bad;

    // Classify the opcode and compare the operand tags against what it needs.
    always_comb begin
        op_bad  = (op > OP_LAST);
        ptr_op  = (op == OP_INC) || (op == OP_DEC);
        if (ptr_op)
            tag_bad = (tag_a != TAG_PTR);
        else
            tag_bad = (tag_a != TAG_INT) || (tag_b != TAG_INT);
        if (op_bad)
            cause = CAUSE_OP;
        else if (tag_bad)
            cause = CAUSE_TAG;
        else
            cause = CAUSE_NONE;
    end
endmodule

// File: rtl/tagalu_bitwise.sv
// Bitwise logic and logical barrel shifts on integer operands.
// Assumes DW is a power of two; an amount of DW or more shifts everything out.
module tagalu_bitwise
    import tagalu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    localparam int SHW = $clog2(DW);

    logic [DW-1:0] lsh [0:SHW];
    logic [DW-1:0] rsh [0:SHW];
    logic          too_far;

    assign lsh[0]  = a;
    assign rsh[0]  = a;
    assign too_far = |b[DW-1:SHW];

    // One shifter stage for each bit of the amount, in both directions.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign lsh[k+1] = b[k] ? (lsh[k] << (1 << k)) : lsh[k];
        assign rsh[k+1] = b[k] ? (rsh[k] >> (1 << k)) : rsh[k];
    end

    // Select the operation result.
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = too_far ? '0 : lsh[SHW];
            OP_SHR:  y = too_far ? '0 : rsh[SHW];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tagalu_ptrstep.sv
// Pointer step by a small unsigned immediate, wrapping modulo 2^DW.
// Assumes IW < DW.
module tagalu_ptrstep #(
    parameter int DW = 16,
    parameter int IW = 4
) (
    input  logic          down,
    input  logic [DW-1:0] a,
    input  logic [IW-1:0] imm,
    output logic [DW-1:0] y
);
    logic [DW-1:0] step;

    assign step = {{(DW-IW){1'b0}}, imm};

    // Add or subtract the zero-extended step; wrap-around is intended.
    always_comb begin
        if (down)
            y = a - step;
        else
            y = a + step;
    end
endmodule

// File: rtl/tagalu_core.sv
// Tag-checked ALU top: checks tags, computes, registers the result or trap.
// One cycle of latency; outputs are zero when nothing was issued or on a trap.
module tagalu_core
    import tagalu_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [TAG_W-1:0]   a_tag,
    input  logic [DW-1:0]      a_val,
    input  logic [TAG_W-1:0]   b_tag,
    input  logic [DW-1:0]      b_val,
    input  logic [IW-1:0]      in_imm,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag,
    output logic [DW-1:0]      out_val,
    output logic               out_trap,
    output logic [CAUSE_W-1:0] out_cause
);
    cause_e        cause;
    logic          ptr_op;
    logic [DW-1:0] logic_y;
    logic [DW-1:0] ptr_y;
    logic [TAG_W-1:0] nxt_tag;
    logic [DW-1:0]    nxt_val;

    tagalu_decode u_dec (
        .op    (in_op),
        .tag_a (a_tag),
        .tag_b (b_tag),
        .cause (cause),
        .ptr_op(ptr_op)
    );

    tagalu_bitwise #(.DW(DW)) u_bit (
        .op(in_op),
        .a (a_val),
        .b (b_val),
        .y (logic_y)
    );

    tagalu_ptrstep #(.DW(DW), .IW(IW)) u_ptr (
        .down(in_op == OP_DEC),
        .a   (a_val),
        .imm (in_imm),
        .y   (ptr_y)
    );

    // Pick the tagged result, or zero it when the operation faults.
    always_comb begin
        if (cause != CAUSE_NONE) begin
            nxt_tag = TAG_INT;
            nxt_val = '0;
        end else if (ptr_op) begin
            nxt_tag = TAG_PTR;
            nxt_val = ptr_y;
        end else begin
            nxt_tag = TAG_INT;
            nxt_val = logic_y;
        end
    end

    // Output register; cleared by reset and in cycles without an issue.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_val   <= '0;
            out_trap  <= 1'b0;
            out_cause <= CAUSE_NONE;
        end else begin
            out_valid <= 1'b1;
            out_tag   <= nxt_tag;
            out_val   <= nxt_val;
            out_trap  <= (cause != CAUSE_NONE);
            out_cause <= cause;
        end
    end
endmodule

// File: rtl/tagalu_sva.sv
// Checker for tagalu_core: timing, trap shape and tag of results.
// Attached to every tagalu_core instance by the bind at the end of this file.
module tagalu_sva
    import tagalu_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [OP_W-1:0]    in_op,
    input logic [TAG_W-1:0]   a_tag,
    input logic [IW-1:0]      in_imm,
    input logic               out_valid,
    input logic [TAG_W-1:0]   out_tag,
    input logic [DW-1:0]      out_val,
    input logic               out_trap,
    input logic [CAUSE_W-1:0] out_cause
);
    // R2: issue gives a result one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no issue, quiet outputs next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_val == '0 && !out_trap));

    // R8: trapped result is zeroed
    a_r8_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_val == '0 && out_tag == '0));

    // R10: cause and trap agree, trap only with valid
    a_r10_cause_match: assert property (@(posedge clk) disable iff (!rst_n)
        (out_trap == (out_cause != '0)) && (!out_trap || out_valid));

    // R9: undefined opcode reports the opcode cause
    a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OP_LAST) |=> (out_trap && out_cause == CAUSE_OP));

    // R6: pointer step on a pointer keeps the pointer tag
    a_r6_ptr_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_INC || in_op == OP_DEC) && a_tag == TAG_PTR)
        |=> (!out_trap && out_tag == TAG_PTR));

    // R3: a defined logic opcode never yields a pointer tag
    a_r3_int_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op <= OP_SHR) |=> (out_tag == TAG_INT));
endmodule

bind tagalu_core tagalu_sva #(.DW(DW), .IW(IW)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .a_tag    (a_tag),
    .in_imm   (in_imm),
    .out_valid(out_valid),
    .out_tag  (out_tag),
    .out_val  (out_val),
    .out_trap (out_trap),
    .out_cause(out_cause)
);

// File: tb/sim_tagalu_core.sv
`timescale 1ns/1ps
// Bench for tagalu_core: behavioural reference compared on every clock.
module sim_tagalu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [2:0]  a_tag = '0;
    logic [15:0] a_val = '0;
    logic [2:0]  b_tag = '0;
    logic [15:0] b_val = '0;
    logic [3:0]  in_imm = '0;
    logic        out_valid;
    logic [2:0]  out_tag;
    logic [15:0] out_val;
    logic        out_trap;
    logic [1:0]  out_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected outputs for the next comparison
    logic        e_valid, e_trap;
    logic [2:0]  e_tag;
    logic [15:0] e_val;
    logic [1:0]  e_cause;
    string       e_req;

    always #2 clk = ~clk;

    tagalu_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .a_tag(a_tag), .a_val(a_val), .b_tag(b_tag), .b_val(b_val),
        .in_imm(in_imm), .out_valid(out_valid), .out_tag(out_tag),
        .out_val(out_val), .out_trap(out_trap), .out_cause(out_cause)
    );

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || out_trap !== e_trap || out_cause !== e_cause ||
            out_tag !== e_tag || out_val !== e_val) begin
            errors++;
            $display("FAIL %s: got v=%0d t=%0d c=%0d tag=%0d val=%h, want v=%0d t=%0d c=%0d tag=%0d val=%h",
                     e_req, out_valid, out_trap, out_cause, out_tag, out_val,
                     e_valid, e_trap, e_cause, e_tag, e_val);
        end
    endtask

    // Reference model: sets the expected outputs for one issued request.
    task automatic model(input bit v, input int op, input int at, input int av,
                         input int bt, input int bv, input int imm);
        int r;
        e_valid = v; e_trap = 0; e_cause = 0; e_tag = 0; e_val = 0;
        if (!v) begin e_req = "R2"; return; end
        if (op > 6) begin
            e_trap = 1; e_cause = 2; e_req = "R9"; return;
        end
        if (op >= 5) begin
            if (at != 1) begin e_trap = 1; e_cause = 1; e_req = "R8"; return; end
            r = (op == 5) ? (av + imm) : (av - imm + 65536);
            e_tag = 1; e_val = 16'(r % 65536);
            e_req = (op == 5) ? "R6" : "R7";
            return;
        end
        if (at != 0 || bt != 0) begin e_trap = 1; e_cause = 1; e_req = "R8"; return; end
        case (op)
            0: begin r = av & bv; e_req = "R3"; end
            1: begin r = av | bv; e_req = "R3"; end
            2: begin r = av ^ bv; e_req = "R3"; end
            3: begin r = (bv >= 16) ? 0 : ((av * (1 << bv)) % 65536); e_req = "R4"; end
            default: begin r = (bv >= 16) ? 0 : (av / (1 << bv)); e_req = "R5"; end
        endcase
        e_val = 16'(r);
    endtask

    // Drive one cycle at the falling edge, then compare at the next one.
    task automatic step(input bit v, input int op, input int at, input int av,
                        input int bt, input int bv, input int imm);
        in_valid = v; in_op = 4'(op); a_tag = 3'(at); a_val = 16'(av);
        b_tag = 3'(bt); b_val = 16'(bv); in_imm = 4'(imm);
        model(v, op, at, av, bt, bv, imm);
        @(negedge clk);
        compare();
    endtask

    initial begin
        // R1: outputs zero while in reset (valid held high to show it is ignored)
        in_valid = 1; in_op = 4'd1; a_val = 16'hFFFF; b_val = 16'hFFFF;
        repeat (3) @(negedge clk);
        e_valid = 0; e_trap = 0; e_cause = 0; e_tag = 0; e_val = 0; e_req = "R1";
        compare();
        in_valid = 0;
        rst_n = 1;
        @(negedge clk);
        e_req = "R1";
        compare();

        step(1, 0, 0, 16'hF0F0, 0, 16'h3C3C, 0);   // R3 AND
        step(1, 1, 0, 16'hF000, 0, 16'h000F, 0);   // R3 OR
        step(1, 2, 0, 16'hAAAA, 0, 16'hFFFF, 0);   // R3 XOR
        step(0, 2, 0, 16'h1234, 0, 16'h1, 0);      // R2 idle gives zeros
        step(1, 3, 0, 16'h8001, 0, 1, 0);          // R4 SHL
        step(1, 3, 0, 16'h0001, 0, 15, 0);         // R4 SHL by 15
        step(1, 3, 0, 16'hFFFF, 0, 16, 0);         // R4 amount 16 gives zero
        step(1, 3, 0, 16'hFFFF, 0, 16'h0101, 0);   // R4 high amount bits give zero
        step(1, 4, 0, 16'h8000, 0, 15, 0);         // R5 SHR zero fill
        step(1, 4, 0, 16'hFFFF, 0, 4, 0);          // R5 SHR no sign fill
        step(1, 4, 0, 16'hFFFF, 0, 16'h8000, 0);   // R5 large amount
        step(1, 5, 1, 16'h0100, 0, 0, 7);          // R6 INC
        step(1, 5, 1, 16'hFFFE, 5, 16'hBEEF, 15);  // R6 wrap, b ignored
        step(1, 6, 1, 16'h0100, 0, 0, 3);          // R7 DEC
        step(1, 6, 1, 16'h0002, 7, 16'h1234, 9);   // R7 wrap below zero, b ignored
        step(1, 5, 0, 16'h0100, 1, 0, 1);          // R8 INC on INT
        step(1, 6, 2, 16'h0100, 1, 0, 1);          // R8 DEC on CONT
        step(1, 0, 1, 16'h00FF, 0, 16'h00FF, 0);   // R8 AND with PTR
        step(1, 2, 0, 16'h00FF, 3, 16'h00FF, 0);   // R8 XOR with CLOSURE b
        step(1, 4, 6, 16'h00FF, 0, 1, 0);          // R8 reserved tag
        step(1, 7, 0, 16'h00FF, 0, 1, 0);          // R9 op 7
        step(1, 15, 5, 16'h00FF, 7, 1, 3);         // R9 outranks bad tags
        step(1, 9, 1, 16'h00FF, 1, 1, 3);          // R9 op 9 with PTR tags
        step(1, 1, 0, 16'h0F00, 0, 16'h00F0, 0);   // R10 back-to-back after trap
        step(0, 0, 0, 0, 0, 0, 0);                 // R2 idle

        for (int i = 0; i < 400; i++) begin
            int op, at, bt;
            op = (($urandom % 4) == 0) ? int'($urandom % 16) : int'($urandom % 7);
            if ($urandom % 2) begin
                at = (op == 5 || op == 6) ? 1 : 0;
                bt = 0;
            end else begin
                at = $urandom % 8;
                bt = $urandom % 8;
            end
            step(($urandom % 8) != 0, op, at, int'($urandom % 65536), bt,
                 (($urandom % 3) == 0) ? int'($urandom % 65536) : int'($urandom % 20),
                 int'($urandom % 16));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion, want completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule